// File: doc/BRIEF.md
# Subtractive Decode Claim Unit

This unit sits on the bridge side of a parallel shared bus and acts as the catch-all target. Every transaction that no other agent on the bus claims by positive decode is taken by this unit and forwarded toward the lower-level bus. The unit makes no address comparison at all. It claims purely because nobody else answered within the positive-decode window.

On the first clock edge where the bus is idle and the frame strobe is seen low, the unit captures the address and command. It then watches the shared device-select line for a fixed number of edges. If no other agent pulls device-select low in that window, the unit drives its own device-select low. It also hands the captured address and command to a single-entry downstream slot, which presents them with a valid/ready handshake.

If the slot still holds an earlier request at the moment of claiming, the unit answers with a target retry: device-select and stop are both driven low. The slot contents are left untouched. In every case, the unit's outputs return high after the first edge at which the frame strobe and the initiator-ready strobe are both seen high.

Top module: `sdc_claim_unit`

## Requirements
- R1: While reset is asserted and right after it, `tgt_devsel_n` and `tgt_stop_n` are 1 and `dn_valid` is 0.
- R2: The address edge is the first rising clock edge at which `bus_frame_n` is sampled 0 while the unit is idle. `bus_ad` and `bus_cbe` are captured at that edge, and later changes on them do not alter the forwarded request.
- R3: Call the address edge E0 and the following edges E1, E2, E3 (WINDOW = 3). If `bus_devsel_n` is sampled 1 at E1..E3, `tgt_devsel_n` goes to 0 right after E3 and not earlier.
- R4: The claim in R3 happens for every address and command value, with no address range check.
- R5: If `bus_devsel_n` is sampled 0 at any of E1..E3, `tgt_devsel_n` and `tgt_stop_n` stay 1 for that transaction and the downstream slot is unchanged.
- R6: Once claimed (or retried), `tgt_devsel_n` stays 0 until the first edge at which `bus_frame_n` and `bus_irdy_n` are both sampled 1. The outputs are 1 right after that edge.
- R7: On a normal claim, `dn_valid` rises at the same edge as the claim, with `dn_addr` and `dn_cmd` equal to the values captured at the address edge.
- R8: `dn_valid`, `dn_addr` and `dn_cmd` hold steady while `dn_ready` is 0. `dn_valid` clears at the first edge where `dn_ready` is sampled 1.
- R9: If `dn_valid` is 1 at the claim edge, the unit retries: `tgt_devsel_n` and `tgt_stop_n` both go to 0, and the slot keeps its old request.
- R10: A transaction whose frame and initiator-ready strobes are both sampled 1 before the claim edge is not claimed.
- R11: `tgt_stop_n` is never 0 while `tgt_devsel_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_frame_n | input | 1 | Frame strobe, active low |
| bus_irdy_n | input | 1 | Initiator-ready strobe, active low |
| bus_devsel_n | input | 1 | Shared device-select line as seen on the bus, active low |
| bus_ad | input | ADDR_W | Multiplexed address/data lines |
| bus_cbe | input | CMD_W | Command/byte-enable lines |
| tgt_devsel_n | output | 1 | This unit's device-select drive, active low |
| tgt_stop_n | output | 1 | This unit's stop drive, active low (retry) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_cmd | output | CMD_W | Forwarded command |

## Verification
The main function is swept over four claim patterns: no other claimer, and another agent claiming at the first, second or third window edge. This separates a correct window length from one edge too short or too long. Each pattern is repeated with all-zeros, all-ones, alternating and single-bit addresses, and every command value. This shows that the claim ignores the address and that every capture bit reaches the slot. The bus lines are changed after the address edge to show that capture happens at that edge. A second transaction arriving while the slot is still full tells the retry path apart from a normal claim. A transaction that ends inside the window shows that an early bus idle cancels the claim.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT    = 3'd1,
    ST_CLAIM   = 3'd2,
    ST_RETRY   = 3'd3,
    ST_BACKOFF = 3'd4
  } sdc_state_e;
endpackage

// File: rtl/sdc_window_timer.sv
module sdc_window_timer #(
  parameter int WINDOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic advance,
  output logic done
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (advance && (cnt_q != LIMIT)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/sdc_req_slot.sv
module sdc_req_slot #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [CMD_W-1:0]  cap_cmd,
  input  logic              load,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd
);
  logic [ADDR_W-1:0] hold_addr_q;
  logic [CMD_W-1:0]  hold_cmd_q;
  logic              valid_q, valid_d, valid_en;
  logic [ADDR_W-1:0] out_addr_q;
  logic [CMD_W-1:0]  out_cmd_q;

  // address-phase capture stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr_q <= '0;
      hold_cmd_q  <= '0;
    end else if (cap_en) begin
      hold_addr_q <= cap_addr;
      hold_cmd_q  <= cap_cmd;
    end
  end

  always_comb begin
    valid_en = 1'b0;
    valid_d  = valid_q;
    if (load) begin
      valid_en = 1'b1;
      valid_d  = 1'b1;
    end else if (valid_q && ready) begin
      valid_en = 1'b1;
      valid_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= 1'b0;
    else if (valid_en) valid_q <= valid_d;
  end

  // downstream presentation stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr_q <= '0;
      out_cmd_q  <= '0;
    end else if (load) begin
      out_addr_q <= hold_addr_q;
      out_cmd_q  <= hold_cmd_q;
    end
  end

  assign valid = valid_q;
  assign addr  = out_addr_q;
  assign cmd   = out_cmd_q;
endmodule

// File: rtl/sdc_claim_fsm.sv
module sdc_claim_fsm
  import sdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic devsel_n,
  input  logic win_done,
  input  logic slot_busy,
  output logic tmr_start,
  output logic tmr_advance,
  output logic slot_load,
  output logic drv_devsel_n,
  output logic drv_stop_n
);
  sdc_state_e st_q, st_d;
  logic       bus_end;

  assign bus_end = frame_n && irdy_n;

  always_comb begin
    st_d        = st_q;
    tmr_start   = 1'b0;
    tmr_advance = 1'b0;
    slot_load   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!frame_n) begin
          st_d      = ST_WAIT;
          tmr_start = 1'b1;
        end
      end
      ST_WAIT: begin
        if (bus_end) begin
          st_d = ST_IDLE;
        end else if (!devsel_n) begin
          st_d = ST_BACKOFF;
        end else if (win_done) begin
          if (slot_busy) begin
            st_d = ST_RETRY;
          end else begin
            st_d      = ST_CLAIM;
            slot_load = 1'b1;
          end
        end else begin
          tmr_advance = 1'b1;
        end
      end
      ST_CLAIM, ST_RETRY, ST_BACKOFF: begin
        if (bus_end) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign drv_devsel_n = !((st_q == ST_CLAIM) || (st_q == ST_RETRY));
  assign drv_stop_n   = !(st_q == ST_RETRY);
endmodule

// File: rtl/sdc_claim_unit.sv
module sdc_claim_unit #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int WINDOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_frame_n,
  input  logic              bus_irdy_n,
  input  logic              bus_devsel_n,
  input  logic [ADDR_W-1:0] bus_ad,
  input  logic [CMD_W-1:0]  bus_cbe,
  output logic              tgt_devsel_n,
  output logic              tgt_stop_n,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [CMD_W-1:0]  dn_cmd
);
  logic tmr_start, tmr_advance, win_done, slot_load;

  sdc_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .advance (tmr_advance),
    .done    (win_done)
  );

  sdc_claim_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (bus_frame_n),
    .irdy_n       (bus_irdy_n),
    .devsel_n     (bus_devsel_n),
    .win_done     (win_done),
    .slot_busy    (dn_valid),
    .tmr_start    (tmr_start),
    .tmr_advance  (tmr_advance),
    .slot_load    (slot_load),
    .drv_devsel_n (tgt_devsel_n),
    .drv_stop_n   (tgt_stop_n)
  );

  sdc_req_slot #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (tmr_start),
    .cap_addr (bus_ad),
    .cap_cmd  (bus_cbe),
    .load     (slot_load),
    .ready    (dn_ready),
    .valid    (dn_valid),
    .addr     (dn_addr),
    .cmd      (dn_cmd)
  );
endmodule

// File: rtl/sdc_claim_unit_chk.sv
module sdc_claim_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int WINDOW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_frame_n,
  input logic              bus_irdy_n,
  input logic              bus_devsel_n,
  input logic              tgt_devsel_n,
  input logic              tgt_stop_n,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [CMD_W-1:0]  dn_cmd
);
  logic [7:0] since_q;
  logic       last_end_q;

  // edge count since the address edge, tracked from bus pins only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= 8'hFF;
      last_end_q <= 1'b1;
    end else begin
      last_end_q <= bus_frame_n && bus_irdy_n;
      if (last_end_q && !bus_frame_n) since_q <= 8'd1;
      else if (since_q != 8'hFF)      since_q <= since_q + 8'd1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (tgt_devsel_n && tgt_stop_n && !dn_valid));

  a_r3_claim_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_devsel_n) |-> (since_q == 8'(WINDOW + 1)));

  a_r5_defer_to_other: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_devsel_n && tgt_devsel_n) |=> tgt_devsel_n);

  a_r6_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frame_n && bus_irdy_n) |=> (tgt_devsel_n && tgt_stop_n));

  a_r7_claim_loads_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tgt_devsel_n) && tgt_stop_n) |-> dn_valid);

  a_r8_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_cmd)));

  a_r9_retry_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_stop_n) |-> $past(dn_valid));

  a_r11_stop_with_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_stop_n |-> !tgt_devsel_n);
endmodule

bind sdc_claim_unit sdc_claim_unit_chk #(
  .ADDR_W(ADDR_W), .CMD_W(CMD_W), .WINDOW(WINDOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
  .bus_devsel_n(bus_devsel_n), .tgt_devsel_n(tgt_devsel_n), .tgt_stop_n(tgt_stop_n),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_cmd(dn_cmd)
);

// File: tb/sdc_claim_unit_tb.sv
module sdc_claim_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_frame_n, bus_irdy_n, bus_devsel_n;
  logic [31:0] bus_ad;
  logic [3:0]  bus_cbe;
  logic        tgt_devsel_n, tgt_stop_n, dn_valid, dn_ready;
  logic [31:0] dn_addr;
  logic [3:0]  dn_cmd;

  int  errs;
  int  checks;
  bit  finished;
  bit  exp_pending;
  logic [31:0] exp_addr;
  logic [3:0]  exp_cmd;

  sdc_claim_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
    .bus_devsel_n(bus_devsel_n), .bus_ad(bus_ad), .bus_cbe(bus_cbe),
    .tgt_devsel_n(tgt_devsel_n), .tgt_stop_n(tgt_stop_n), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_cmd(dn_cmd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int p);
    case (p)
      0:       return 32'h0000_0000;
      1:       return 32'hFFFF_FFFF;
      2:       return 32'hA5A5_5A5A;
      default: return 32'h0008_0000;
    endcase
  endfunction

  // claim_at: 0 = nobody else claims, k = other agent pulls devsel low sampled at Ek
  task automatic run_txn(input logic [31:0] a, input logic [3:0] c, input int claim_at,
                         input int data_len, input bit early_end);
    @(negedge clk);
    bus_frame_n = 1'b0; bus_ad = a; bus_cbe = c;
    @(negedge clk);                       // after E0
    bus_frame_n = 1'b1; bus_irdy_n = 1'b0; bus_ad = ~a; bus_cbe = ~c;
    if (claim_at == 1) bus_devsel_n = 1'b0;
    if (early_end) begin
      @(negedge clk);                     // after E1
      bus_irdy_n = 1'b1;
      @(negedge clk);                     // after E2 (bus idle sampled)
      @(negedge clk);                     // after E3
      chk("R10 early end devsel", tgt_devsel_n, 1);
      chk("R10 early end valid", dn_valid, exp_pending);
      return;
    end
    @(negedge clk);                       // after E1
    chk("R3 not early E1", tgt_devsel_n, 1);
    if (claim_at == 2) bus_devsel_n = 1'b0;
    @(negedge clk);                       // after E2
    chk("R3 not early E2", tgt_devsel_n, 1);
    if (claim_at == 3) bus_devsel_n = 1'b0;
    @(negedge clk);                       // after E3
    if (claim_at != 0) begin
      chk("R5 other claim devsel", tgt_devsel_n, 1);
      chk("R5 other claim stop", tgt_stop_n, 1);
      chk("R5 slot untouched", dn_valid, exp_pending);
    end else if (exp_pending) begin
      chk("R9 retry devsel", tgt_devsel_n, 0);
      chk("R9 retry stop", tgt_stop_n, 0);
      chk("R9 slot addr kept", dn_addr, exp_addr);
      chk("R9 slot cmd kept", dn_cmd, exp_cmd);
    end else begin
      chk("R3 R4 claim devsel", tgt_devsel_n, 0);
      chk("R11 claim stop high", tgt_stop_n, 1);
      chk("R7 valid", dn_valid, 1);
      chk("R2 R7 addr", dn_addr, a);
      chk("R2 R7 cmd", dn_cmd, c);
      exp_pending = 1'b1; exp_addr = a; exp_cmd = c;
    end
    for (int i = 0; i < data_len; i++) @(negedge clk);
    if (claim_at == 0) chk("R6 devsel held", tgt_devsel_n, 0);
    bus_irdy_n = 1'b1; bus_devsel_n = 1'b1;
    @(negedge clk);                       // after end edge
    chk("R6 released devsel", tgt_devsel_n, 1);
    chk("R6 released stop", tgt_stop_n, 1);
  endtask

  task automatic accept();
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R8 hold valid", dn_valid, exp_pending);
    chk("R8 hold addr", dn_addr, exp_addr);
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk("R8 cleared on ready", dn_valid, 0);
    exp_pending = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    errs = 0; checks = 0; finished = 0; exp_pending = 0;
    exp_addr = '0; exp_cmd = '0;
    rst_n = 1'b0; bus_frame_n = 1'b1; bus_irdy_n = 1'b1; bus_devsel_n = 1'b1;
    bus_ad = '0; bus_cbe = '0; dn_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset devsel", tgt_devsel_n, 1);
    chk("R1 reset stop", tgt_stop_n, 1);
    chk("R1 reset valid", dn_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", dn_valid, 0);

    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        run_txn(pat(p), 4'(p * 4 + c), c, 1 + c, 1'b0);
        if (c == 0) begin
          if ((p % 2) == 0) run_txn(~pat(p), 4'hF, 0, 2, 1'b0);   // slot full: retry
          run_txn(pat(p) ^ 32'h1, 4'h3, 2, 1, 1'b0);              // other claim, slot full
          accept();
        end
      end
    end

    run_txn(32'h1234_5678, 4'h6, 0, 0, 1'b1);   // R10 early end, slot empty
    run_txn(32'h0BAD_F00D, 4'h7, 0, 0, 1'b0);   // claim afterwards still works
    accept();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule